// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits on the host side of an asynchronous DRAM with 512 rows and keeps the array's contents alive. After reset it waits out the supply settling time. It then runs a fixed number of CAS-before-RAS wake-up cycles, which rely on the row counter inside the device. From then on it issues one CAS-before-RAS refresh for each tick of an interval timer. The tick spacing is chosen so that every row is refreshed within the retention window.

The sequencer shares the RAS and CAS strobes with an access controller. It asks for the bus with `req_o` and drives the strobes only while `gnt_i` is high. Ticks that arrive while the bus is withheld are counted in a saturating backlog. The backlog is then worked off back to back once the grant comes. A flag warns the arbiter when the backlog reaches a set threshold.

On request the sequencer places the device in self-refresh. To do this it starts a CAS-before-RAS cycle and keeps both strobes low. It holds that state for at least a minimum dwell. It releases RAS only once an exit has been requested. A longer precharge then follows before any other cycle may start. All waits and strobe widths are parameters counted in clock cycles.

Top module: `drf_seq`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o` and `cas_n_o` are 1, and `req_o`, `init_done_o`, `in_sr_o` and `urgent_o` are 0.
- R2: `req_o` first goes high exactly `PWRUP_CYC` clock edges after reset is released. Before that, both strobes stay high.
- R3: After the power-up wait the block runs exactly `INIT_CYC` CAS-before-RAS cycles, then raises `init_done_o`. `init_done_o` stays high from then on.
- R4: A strobe is low only while `req_o` and `gnt_i` are both high. A cycle starts only after `gnt_i` is seen high.
- R5: Before every RAS fall, CAS has been high for at least `CAS_PRE` cycles and then low for at least `CAS_LEAD` cycles.
- R6: In a refresh cycle, RAS stays low for `RAS_LOW` cycles and CAS stays low throughout. Both strobes rise together. RAS then stays high for at least `RAS_PRE` cycles before the next fall.
- R7: Once `init_done_o` is high, a refresh tick occurs every `REF_INTERVAL` cycles. Each tick leads to exactly one refresh cycle, issued as soon as the bus is granted.
- R8: The pending-refresh count saturates at `BACKLOG_MAX`. Ticks beyond that are dropped.
- R9: `urgent_o` is high exactly while the pending count is at least `URGENT_TH`.
- R10: A pulse on `sr_enter_i` starts a CAS-before-RAS cycle in which both strobes stay low with `in_sr_o` high. This state lasts `SR_MIN` cycles, or longer if no exit has been requested by then.
- R11: After the dwell, and once an exit has been requested, RAS and CAS rise and `in_sr_o` falls. `req_o` then stays high for exactly `SR_PRE` cycles of precharge.
- R12: While in self-refresh, no refresh ticks are counted and the backlog is cleared. A pulse on `sr_exit_i` outside self-refresh has no effect.
- R13: A pulse on `sr_enter_i` before `init_done_o` rises is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Bus grant from the access arbiter |
| sr_enter_i | input | 1 | One-cycle request to enter self-refresh |
| sr_exit_i | input | 1 | One-cycle request to leave self-refresh |
| req_o | output | 1 | Bus request, high for the whole strobe sequence |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe (drives both byte strobes), active low |
| init_done_o | output | 1 | Power-up wait and wake-up cycles are complete |
| in_sr_o | output | 1 | Device is held in self-refresh |
| urgent_o | output | 1 | Pending-refresh count at or above threshold |

## Verification
The checker assumes that the arbiter never withdraws `gnt_i` while the sequencer still holds a strobe low. The bench's grant model therefore follows `req_o` one half-cycle later and is disabled only while the sequencer is idle. The checker also assumes that `sr_enter_i` and `sr_exit_i` are single-cycle pulses. The bench issues them only while the block is idle or already in self-refresh. All parameters are at least 1, which keeps every counted wait a real state.

// File: rtl/drf_pkg.sv
package drf_pkg;
  typedef enum logic [3:0] {
    ST_PWR, ST_IDLE, ST_REQ, ST_CPRE, ST_CLEAD, ST_RASL, ST_RPRE, ST_SR, ST_SRX
  } drf_state_e;

  typedef enum logic [1:0] {M_INIT, M_REF, M_SR} drf_mode_e;

  function automatic int unsigned drf_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/drf_tick_gen.sv
module drf_tick_gen #(
  parameter int unsigned REF_INTERVAL = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned TW = $clog2(REF_INTERVAL + 1);
  logic [TW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == TW'(REF_INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;   // restart phase whenever disabled
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/drf_backlog.sv
module drf_backlog #(
  parameter int unsigned BACKLOG_MAX = 15,
  parameter int unsigned URGENT_TH   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic done_i,
  input  logic clr_i,
  output logic pend_o,
  output logic urgent_o
);
  localparam int unsigned BW = $clog2(BACKLOG_MAX + 1);
  logic [BW-1:0] cnt_q;

  assign pend_o   = (cnt_q != '0);
  assign urgent_o = (cnt_q >= BW'(URGENT_TH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else begin
      unique case ({tick_i, done_i})
        2'b10:   if (cnt_q != BW'(BACKLOG_MAX)) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/drf_ctrl.sv
module drf_ctrl
  import drf_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 20000,
  parameter int unsigned INIT_CYC  = 8,
  parameter int unsigned CAS_PRE   = 1,
  parameter int unsigned CAS_LEAD  = 1,
  parameter int unsigned RAS_LOW   = 3,
  parameter int unsigned RAS_PRE   = 2,
  parameter int unsigned SR_MIN    = 10000,
  parameter int unsigned SR_PRE    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  input  logic sr_enter_i,
  input  logic sr_exit_i,
  input  logic pend_i,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic init_done_o,
  output logic in_sr_o,
  output logic ref_done_o,
  output logic tick_en_o
);
  localparam int unsigned LONGEST = drf_max(drf_max(PWRUP_CYC, SR_MIN),
                                    drf_max(drf_max(CAS_PRE, CAS_LEAD),
                                    drf_max(drf_max(RAS_LOW, RAS_PRE), SR_PRE)));
  localparam int unsigned CW = $clog2(LONGEST + 1);
  localparam int unsigned IW = $clog2(INIT_CYC + 1);

  drf_state_e    state_q;
  drf_mode_e     mode_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] init_q;
  logic          done_q, sr_req_q, sr_exit_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PWR;
      mode_q    <= M_INIT;
      cnt_q     <= CW'(PWRUP_CYC - 1);
      init_q    <= '0;
      done_q    <= 1'b0;
      sr_req_q  <= 1'b0;
      sr_exit_q <= 1'b0;
    end else begin
      if (sr_enter_i && done_q && state_q != ST_SR && state_q != ST_SRX) sr_req_q <= 1'b1;
      if (sr_exit_i && state_q == ST_SR) sr_exit_q <= 1'b1;
      unique case (state_q)
        ST_PWR:  if (cnt_zero) state_q <= ST_REQ; else cnt_q <= cnt_q - 1'b1;
        ST_IDLE: begin
          if (sr_req_q) begin
            mode_q <= M_SR;  state_q <= ST_REQ;
          end else if (pend_i) begin
            mode_q <= M_REF; state_q <= ST_REQ;
          end
        end
        ST_REQ: if (gnt_i) begin
          state_q <= ST_CPRE; cnt_q <= CW'(CAS_PRE - 1);
        end
        ST_CPRE: if (cnt_zero) begin
          state_q <= ST_CLEAD; cnt_q <= CW'(CAS_LEAD - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_CLEAD: if (cnt_zero) begin
          if (mode_q == M_SR) begin
            state_q <= ST_SR; cnt_q <= CW'(SR_MIN - 1); sr_req_q <= 1'b0;
          end else begin
            state_q <= ST_RASL; cnt_q <= CW'(RAS_LOW - 1);
          end
        end else cnt_q <= cnt_q - 1'b1;
        ST_RASL: if (cnt_zero) begin
          state_q <= ST_RPRE; cnt_q <= CW'(RAS_PRE - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_RPRE: if (cnt_zero) begin
          if (mode_q == M_INIT && init_q != IW'(INIT_CYC - 1)) begin
            init_q <= init_q + 1'b1; state_q <= ST_REQ;
          end else begin
            if (mode_q == M_INIT) done_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end else cnt_q <= cnt_q - 1'b1;
        ST_SR: if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
               else if (sr_exit_q) begin
                 state_q <= ST_SRX; cnt_q <= CW'(SR_PRE - 1); sr_exit_q <= 1'b0;
               end
        ST_SRX: if (cnt_zero) state_q <= ST_IDLE; else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o       = (state_q != ST_PWR) && (state_q != ST_IDLE);
  assign ras_n_o     = !(state_q == ST_RASL || state_q == ST_SR);
  assign cas_n_o     = !(state_q == ST_CLEAD || state_q == ST_RASL || state_q == ST_SR);
  assign init_done_o = done_q;
  assign in_sr_o     = (state_q == ST_SR);
  assign ref_done_o  = (state_q == ST_RPRE) && cnt_zero && (mode_q == M_REF);
  assign tick_en_o   = done_q && state_q != ST_SR && state_q != ST_SRX;
endmodule

// File: rtl/drf_seq.sv
module drf_seq #(
  parameter int unsigned PWRUP_CYC    = 20000,
  parameter int unsigned INIT_CYC     = 8,
  parameter int unsigned CAS_PRE      = 1,
  parameter int unsigned CAS_LEAD     = 1,
  parameter int unsigned RAS_LOW      = 3,
  parameter int unsigned RAS_PRE      = 2,
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned BACKLOG_MAX  = 15,
  parameter int unsigned URGENT_TH    = 8,
  parameter int unsigned SR_MIN       = 10000,
  parameter int unsigned SR_PRE       = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  input  logic sr_enter_i,
  input  logic sr_exit_i,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic init_done_o,
  output logic in_sr_o,
  output logic urgent_o
);
  logic tick, tick_en, pend, ref_done;

  drf_tick_gen #(.REF_INTERVAL(REF_INTERVAL)) u_tick (
    .clk_i, .rst_ni, .en_i(tick_en), .tick_o(tick)
  );

  drf_backlog #(.BACKLOG_MAX(BACKLOG_MAX), .URGENT_TH(URGENT_TH)) u_backlog (
    .clk_i, .rst_ni, .tick_i(tick), .done_i(ref_done), .clr_i(in_sr_o),
    .pend_o(pend), .urgent_o
  );

  drf_ctrl #(
    .PWRUP_CYC(PWRUP_CYC), .INIT_CYC(INIT_CYC), .CAS_PRE(CAS_PRE), .CAS_LEAD(CAS_LEAD),
    .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE), .SR_MIN(SR_MIN), .SR_PRE(SR_PRE)
  ) u_ctrl (
    .clk_i, .rst_ni, .gnt_i, .sr_enter_i, .sr_exit_i, .pend_i(pend),
    .req_o, .ras_n_o, .cas_n_o, .init_done_o, .in_sr_o,
    .ref_done_o(ref_done), .tick_en_o(tick_en)
  );
endmodule

// File: rtl/drf_seq_chk.sv
module drf_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic gnt_i,
  input logic req_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic init_done_o,
  input logic in_sr_o
);
  a_r4_strobe_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> req_o);

  a_r4_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> gnt_i);

  a_r5_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  a_r6_cas_low_with_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !cas_n_o);

  a_r6_rise_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> $rose(cas_n_o));

  a_r10_sr_strobes_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sr_o |-> (!ras_n_o && !cas_n_o));

  a_r11_exit_lifts_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_sr_o) |-> (ras_n_o && req_o));

  a_r13_sr_after_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sr_o |-> init_done_o);

  a_r3_init_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
endmodule

bind drf_seq drf_seq_chk u_drf_seq_chk (
  .clk_i, .rst_ni, .gnt_i, .req_o, .ras_n_o, .cas_n_o, .init_done_o, .in_sr_o
);

// File: tb/test_drf_seq.sv
module test_drf_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PWRUP = 50, INIT = 8, CPRE = 2, CLEAD = 1, RLOW = 3, RPRE = 2;
  localparam int INTV = 40, BMAX = 15, UTH = 8, SRMIN = 100, SRPRE = 5;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0, sr_en = 1'b0, sr_ex = 1'b0;
  logic req, ras_n, cas_n, init_done, in_sr, urgent;
  logic allow = 1'b0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drf_seq #(
    .PWRUP_CYC(PWRUP), .INIT_CYC(INIT), .CAS_PRE(CPRE), .CAS_LEAD(CLEAD),
    .RAS_LOW(RLOW), .RAS_PRE(RPRE), .REF_INTERVAL(INTV), .BACKLOG_MAX(BMAX),
    .URGENT_TH(UTH), .SR_MIN(SRMIN), .SR_PRE(SRPRE)
  ) i_drf_seq (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .sr_enter_i(sr_en), .sr_exit_i(sr_ex),
    .req_o(req), .ras_n_o(ras_n), .cas_n_o(cas_n), .init_done_o(init_done),
    .in_sr_o(in_sr), .urgent_o(urgent)
  );

  // arbiter model: grants half a cycle after the request while allowed
  always @(negedge clk) gnt <= allow && req;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // strobe monitor
  int cyc = 0, first_req = -1, ras_falls = 0;
  int ras_hi = 0, ras_lo = 0, cas_hi = 0, cas_lo = 0, cas_hi_at_fall = 0;
  logic p_ras = 1'b1, p_cas = 1'b1;
  bit saw_sr = 0, after_sr = 0;

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (first_req < 0 && req) first_req = cyc;
      if (p_cas && !cas_n) cas_hi_at_fall = cas_hi;
      if (p_ras && !ras_n) begin
        ras_falls++;
        check(req && gnt, "R4 strobe under grant", int'(req && gnt), 1);
        check(cas_lo >= CLEAD, "R5 cas lead", cas_lo, CLEAD);
        check(cas_hi_at_fall >= CPRE, "R5 cas high before fall", cas_hi_at_fall, CPRE);
        if (after_sr) check(ras_hi >= SRPRE, "R11 precharge after exit", ras_hi, SRPRE);
        else          check(ras_hi >= RPRE, "R6 ras precharge", ras_hi, RPRE);
        after_sr = 0;
        saw_sr = 0;
      end
      if (in_sr) saw_sr = 1;
      if (!p_ras && ras_n) begin
        check(cas_n == 1'b1, "R6 cas rises with ras", int'(cas_n), 1);
        if (saw_sr) begin
          check(ras_lo >= SRMIN, "R10 self-refresh dwell", ras_lo, SRMIN);
          after_sr = 1;
        end else check(ras_lo == RLOW, "R6 ras low width", ras_lo, RLOW);
      end
      ras_hi = (ras_n && p_ras) ? ras_hi + 1 : (ras_n ? 1 : 0);
      ras_lo = (!ras_n && !p_ras) ? ras_lo + 1 : (!ras_n ? 1 : 0);
      cas_hi = (cas_n && p_cas) ? cas_hi + 1 : (cas_n ? 1 : 0);
      cas_lo = (!cas_n && !p_cas) ? cas_lo + 1 : (!cas_n ? 1 : 0);
      p_ras = ras_n;
      p_cas = cas_n;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      q = req ? 0 : q + 1;
    end
  endtask

  task automatic pulse_enter();
    @(negedge clk); sr_en = 1'b1;
    @(negedge clk); sr_en = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk); sr_ex = 1'b1;
    @(negedge clk); sr_ex = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wait_cyc(3);
    check(ras_n && cas_n, "R1 strobes idle in reset", int'({ras_n, cas_n}), 3);
    check(!req && !init_done && !in_sr && !urgent, "R1 flags low in reset",
          int'({req, init_done, in_sr, urgent}), 0);
    allow = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic t_powerup();
    int t = 0;
    wait_cyc(10);
    pulse_enter();   // must be ignored (R13)
    while (!init_done && t < 2000) begin @(negedge clk); t++; end
    check(first_req == PWRUP, "R2 power-up wait", first_req, PWRUP);
    check(ras_falls == INIT, "R3 wake-up cycle count", ras_falls, INIT);
    wait_cyc(5);
    check(!in_sr && ras_n, "R13 early enter ignored", int'(in_sr), 0);
    check(init_done, "R3 init_done held", int'(init_done), 1);
  endtask

  task automatic t_periodic();
    int f0, d;
    wait_quiet();
    f0 = ras_falls;
    wait_cyc(10 * INTV);
    d = ras_falls - f0;
    check(d >= 9 && d <= 11, "R7 one refresh per interval", d, 10);
  endtask

  task automatic t_urgent();
    int f0, d;
    wait_quiet();
    allow = 1'b0;
    wait_cyc((UTH - 1) * INTV - 1);
    check(!urgent, "R9 urgent low below threshold", int'(urgent), 0);
    wait_cyc(INTV + 2);
    check(urgent, "R9 urgent at threshold", int'(urgent), 1);
    f0 = ras_falls;
    allow = 1'b1;
    wait_quiet();
    d = ras_falls - f0;
    check(d >= UTH && d <= UTH + 3, "R7 backlog flushed", d, UTH);
    check(!urgent, "R9 urgent clears after flush", int'(urgent), 0);
  endtask

  task automatic t_saturate();
    int f0, d;
    wait_quiet();
    allow = 1'b0;
    wait_cyc((BMAX + 10) * INTV);
    check(urgent, "R9 urgent while starved", int'(urgent), 1);
    f0 = ras_falls;
    allow = 1'b1;
    wait_quiet();
    d = ras_falls - f0;
    check(d >= BMAX && d <= BMAX + 5, "R8 backlog saturates", d, BMAX);
  endtask

  task automatic sr_stay(input int exit_after, output int n_sr, output int n_pre);
    int t = 0;
    pulse_enter();
    while (!in_sr && t < 100) begin @(negedge clk); t++; end
    check(in_sr && !ras_n && !cas_n, "R10 self-refresh entered", int'({in_sr, ras_n, cas_n}), 4);
    n_sr = 0;
    fork
      begin wait_cyc(exit_after); pulse_exit(); end
      while (in_sr) begin n_sr++; @(negedge clk); end
    join
    check(ras_n && cas_n, "R11 strobes high on exit", int'({ras_n, cas_n}), 3);
    n_pre = 0;
    while (req && n_pre < 1000) begin n_pre++; @(negedge clk); end
  endtask

  task automatic t_selfref();
    int n_sr, n_pre, f0;
    wait_quiet();
    sr_stay(2, n_sr, n_pre);
    check(n_sr == SRMIN, "R10 minimum dwell on early exit", n_sr, SRMIN);
    check(n_pre == SRPRE, "R11 exit precharge", n_pre, SRPRE);
    wait_quiet();
    sr_stay(10 * INTV, n_sr, n_pre);
    check(n_sr >= 10 * INTV, "R10 stays until exit", n_sr, 10 * INTV);
    f0 = ras_falls;
    wait_cyc(INTV / 2);
    check(ras_falls == f0, "R12 no ticks kept from self-refresh", ras_falls - f0, 0);
  endtask

  task automatic t_exit_ignored();
    int n_sr, n_pre;
    wait_quiet();
    pulse_exit();
    wait_cyc(10);
    check(!in_sr && ras_n, "R12 stray exit ignored", int'(in_sr), 0);
    sr_stay(SRMIN + 20, n_sr, n_pre);
    check(n_sr >= SRMIN + 20, "R12 stray exit not latched", n_sr, SRMIN + 20);
    wait_quiet();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_periodic();
    t_urgent();
    t_saturate();
    t_selfref();
    t_exit_ignored();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end
endmodule